// File: doc/BRIEF.md
# Zero-Suppressed Column Readout Scanner

After an acquisition, this block walks a pixel matrix column by column and sends what it finds as a stream of words. A one-cycle start pulse does two things. It captures every pixel's hit flag into a private pending store, and it latches a compression select.

With compression on, each column first produces a header word that says whether the column holds any hits. A non-empty column's header is followed by one addressed word for each hit pixel. Pixels with no hit produce nothing. Finding the next hit takes no extra cycles, because a priority encoder on the pending flags of the current column always points at the lowest remaining hit, and each pixel's flag is cleared as its word is accepted. With compression off, every pixel's payload is sent in a fixed column-major order with the address fields held at zero. Every frame ends with a single end-of-frame word.

The output is a valid/ready stream. A word counts as transferred on a clock edge where both `out_valid_o` and `out_ready_i` are high. While `out_ready_i` is low, the scan stops and the word on offer is held unchanged, so back-pressure never loses data. The matrix must keep `pay_i` stable from the start pulse until the end-of-frame word is accepted.

Top module: `zs_col_readout`

## Requirements
- R1: After reset, `out_valid_o` and `out_eof_o` are low, and no word is offered until a start pulse arrives.
- R2: A `start_i` pulse while idle captures `hit_i` and `compress_i`. A start pulse during a frame is ignored. Changes to `hit_i` or `compress_i` after the capture do not alter the frame in progress.
- R3: In compressed mode, every column from 0 up to NCOLS-1 produces exactly one header word, in ascending order. A header has kind 1, `out_col_o` = column, `out_row_o` = 0, `out_pay_o` bit 0 = 1 when the column holds at least one hit, and all other payload bits 0.
- R4: In compressed mode, a non-empty column's header is followed by one pixel word (kind 0) for each hit pixel, in ascending row order. Each pixel word carries the column, the row and that pixel's payload. A pixel with no hit produces no word, and an empty column produces only its header.
- R5: Each captured hit is reported exactly once, because a pixel's pending flag clears when its word is accepted.
- R6: In uncompressed mode, the frame holds NCOLS*NROWS pixel words (kind 0) in column-major order (column 0 rows 0..NROWS-1 first). Each carries the payload whatever its hit flag, with `out_col_o` and `out_row_o` zero. No headers are sent.
- R7: Every frame ends with exactly one end-of-frame word: kind 2, all fields zero, with `out_eof_o` high. After it is accepted, the block is idle with `out_valid_o` low.
- R8: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` stays high and every output field is held stable.
- R9: With `out_ready_i` held high, the first word is offered in the cycle after the start edge, and the block accepts one word per cycle with no gaps. A compressed frame therefore takes NCOLS + hits + 1 cycles.
- R10: Pixel (c, r) uses `hit_i` bit c*NROWS + r and `pay_i` bits [(c*NROWS + r)*PW +: PW].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start-of-scan pulse; captures hit flags and mode while idle |
| compress_i | input | 1 | 1 = zero-suppressed mode, 0 = full raster mode |
| hit_i | input | NCOLS*NROWS | Per-pixel hit flags, index c*NROWS + r |
| pay_i | input | NCOLS*NROWS*PW | Per-pixel counter payloads |
| out_valid_o | output | 1 | A word is offered |
| out_ready_i | input | 1 | Consumer accepts the offered word |
| out_kind_o | output | 2 | 0 pixel, 1 column header, 2 end of frame |
| out_col_o | output | clog2(NCOLS) | Column address |
| out_row_o | output | clog2(NROWS) | Row address |
| out_pay_o | output | PW | Pixel payload, or header non-empty flag in bit 0 |
| out_eof_o | output | 1 | High together with the end-of-frame word |

## Verification
The bench targets the matrix corners (pixel (0,0), row 63 of the last column), columns filled top to bottom, and a frame with no hits at all. A scanner that lost the last column, skipped an empty column's header, or advanced one row per cycle would show up as a wrong word count or a wrong cycle count. A stop-and-go ready pattern tests R8: a design that advanced on valid alone would drop or repeat words. A second start pulse in mid-frame, sent together with a changed mode and an all-ones hit map, would corrupt the stream of a design that accepted it. Back-to-back frames with the same map show that the pending flags are recaptured and each hit is reported once.

// File: rtl/zsr_pkg.sv
package zsr_pkg;
  typedef enum logic [1:0] {
    WK_PIX = 2'd0,
    WK_HDR = 2'd1,
    WK_EOF = 2'd2
  } word_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_PIX,
    ST_RAW,
    ST_EOF
  } scan_state_e;
endpackage

// File: rtl/zsr_hit_store.sv
// Pending-hit store: loaded on start, one flag cleared per accepted pixel.
module zsr_hit_store #(
  parameter int NCOLS = 64,
  parameter int NROWS = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load_i,
  input  logic [NCOLS*NROWS-1:0]     hit_i,
  input  logic                       clr_en_i,
  input  logic [$clog2(NCOLS)-1:0]   clr_col_i,
  input  logic [$clog2(NROWS)-1:0]   clr_row_i,
  output logic [NCOLS*NROWS-1:0]     pend_o,
  output logic [NCOLS-1:0]           col_any_o
);
  localparam int NPIX = NCOLS * NROWS;
  localparam int IW   = $clog2(NPIX);

  logic [NPIX-1:0] pend_q;
  logic [IW-1:0]   clr_idx;

  assign clr_idx = IW'(clr_col_i) * IW'(NROWS) + IW'(clr_row_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (load_i) begin
      pend_q <= hit_i;
    end else if (clr_en_i) begin
      pend_q[clr_idx] <= 1'b0;
    end
  end

  for (genvar c = 0; c < NCOLS; c++) begin : g_col
    assign col_any_o[c] = |pend_q[c*NROWS +: NROWS];
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/zsr_first_set.sv
// Lowest-set-bit finder with a flag for further set bits above it.
module zsr_first_set #(
  parameter int W = 64
) (
  input  logic [W-1:0]         in_i,
  output logic                 any_o,
  output logic                 more_o,
  output logic [$clog2(W)-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (in_i[i]) idx_o = ($clog2(W))'(i);
    end
  end

  assign any_o  = |in_i;
  assign more_o = |(in_i & (in_i - W'(1)));
endmodule

// File: rtl/zsr_scan_ctrl.sv
// Scan sequencer: header / hit-pixel / raster / end-of-frame states.
module zsr_scan_ctrl
  import zsr_pkg::*;
#(
  parameter int NCOLS = 64,
  parameter int NROWS = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic                     compress_i,
  input  logic                     col_nonempty_i,
  input  logic                     hit_more_i,
  input  logic                     ready_i,
  output scan_state_e              st_o,
  output logic [$clog2(NCOLS)-1:0] col_o,
  output logic [$clog2(NROWS)-1:0] raw_row_o,
  output logic                     load_o
);
  localparam int CW = $clog2(NCOLS);
  localparam int RW = $clog2(NROWS);
  localparam logic [CW-1:0] LAST_COL = CW'(NCOLS - 1);
  localparam logic [RW-1:0] LAST_ROW = RW'(NROWS - 1);

  scan_state_e    st_q;
  logic [CW-1:0]  col_q;
  logic [RW-1:0]  row_q;

  assign load_o = (st_q == ST_IDLE) && start_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      col_q <= '0;
      row_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q  <= compress_i ? ST_HDR : ST_RAW;
          col_q <= '0;
          row_q <= '0;
        end
        ST_HDR: if (ready_i) begin
          if (col_nonempty_i)         st_q  <= ST_PIX;
          else if (col_q == LAST_COL) st_q  <= ST_EOF;
          else                        col_q <= col_q + 1'b1;
        end
        ST_PIX: if (ready_i && !hit_more_i) begin
          if (col_q == LAST_COL) begin
            st_q <= ST_EOF;
          end else begin
            col_q <= col_q + 1'b1;
            st_q  <= ST_HDR;
          end
        end
        ST_RAW: if (ready_i) begin
          if (row_q == LAST_ROW) begin
            row_q <= '0;
            if (col_q == LAST_COL) st_q  <= ST_EOF;
            else                   col_q <= col_q + 1'b1;
          end else begin
            row_q <= row_q + 1'b1;
          end
        end
        ST_EOF: if (ready_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign st_o      = st_q;
  assign col_o     = col_q;
  assign raw_row_o = row_q;
endmodule

// File: rtl/zs_col_readout.sv
// Zero-suppressed column readout top.
module zs_col_readout
  import zsr_pkg::*;
#(
  parameter int NCOLS = 64,
  parameter int NROWS = 64,
  parameter int PW    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_i,
  input  logic                        compress_i,
  input  logic [NCOLS*NROWS-1:0]      hit_i,
  input  logic [NCOLS*NROWS*PW-1:0]   pay_i,
  output logic                        out_valid_o,
  input  logic                        out_ready_i,
  output logic [1:0]                  out_kind_o,
  output logic [$clog2(NCOLS)-1:0]    out_col_o,
  output logic [$clog2(NROWS)-1:0]    out_row_o,
  output logic [PW-1:0]               out_pay_o,
  output logic                        out_eof_o
);
  localparam int NPIX = NCOLS * NROWS;
  localparam int CW   = $clog2(NCOLS);
  localparam int RW   = $clog2(NROWS);
  localparam int IW   = $clog2(NPIX);
  localparam int PIW  = $clog2(NPIX * PW);

  scan_state_e      st;
  logic [CW-1:0]    col;
  logic [RW-1:0]    raw_row;
  logic             load;
  logic [NPIX-1:0]  pend;
  logic [NCOLS-1:0] col_any;
  logic [NROWS-1:0] col_bits;
  logic             col_nonempty;
  logic             hit_any;
  logic             hit_more;
  logic [RW-1:0]    hit_row;
  logic [RW-1:0]    rd_row;
  logic             is_pix;
  logic             fire;
  logic [IW-1:0]    pix_idx;
  logic [PIW-1:0]   pay_base;

  zsr_scan_ctrl #(.NCOLS(NCOLS), .NROWS(NROWS)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .compress_i     (compress_i),
    .col_nonempty_i (col_nonempty),
    .hit_more_i     (hit_more),
    .ready_i        (out_ready_i),
    .st_o           (st),
    .col_o          (col),
    .raw_row_o      (raw_row),
    .load_o         (load)
  );

  zsr_hit_store #(.NCOLS(NCOLS), .NROWS(NROWS)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load),
    .hit_i     (hit_i),
    .clr_en_i  (fire && is_pix),
    .clr_col_i (col),
    .clr_row_i (rd_row),
    .pend_o    (pend),
    .col_any_o (col_any)
  );

  assign col_bits     = pend[IW'(col) * IW'(NROWS) +: NROWS];
  assign col_nonempty = col_any[col];

  zsr_first_set #(.W(NROWS)) u_first (
    .in_i   (col_bits),
    .any_o  (hit_any),
    .more_o (hit_more),
    .idx_o  (hit_row)
  );

  assign is_pix   = (st == ST_PIX) || (st == ST_RAW);
  assign rd_row   = (st == ST_PIX) ? hit_row : raw_row;
  assign pix_idx  = IW'(col) * IW'(NROWS) + IW'(rd_row);
  assign pay_base = PIW'(pix_idx) * PIW'(PW);

  assign out_valid_o = (st != ST_IDLE);
  assign fire        = out_valid_o && out_ready_i;
  assign out_eof_o   = (st == ST_EOF);

  always_comb begin
    out_kind_o = WK_PIX;
    out_col_o  = '0;
    out_row_o  = '0;
    out_pay_o  = '0;
    unique case (st)
      ST_HDR: begin
        out_kind_o = WK_HDR;
        out_col_o  = col;
        out_pay_o  = PW'(col_nonempty);
      end
      ST_PIX: begin
        out_kind_o = WK_PIX;
        out_col_o  = col;
        out_row_o  = hit_any ? hit_row : '0;
        out_pay_o  = pay_i[pay_base +: PW];
      end
      ST_RAW: begin
        out_kind_o = WK_PIX;
        out_pay_o  = pay_i[pay_base +: PW];
      end
      ST_EOF:  out_kind_o = WK_EOF;
      default: out_kind_o = WK_PIX;
    endcase
  end
endmodule

// File: rtl/zsr_checker.sv
// Protocol checks on the readout stream, bound to the top module.
module zsr_checker #(
  parameter int NCOLS = 64,
  parameter int NROWS = 64,
  parameter int PW    = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     out_valid_o,
  input logic                     out_ready_i,
  input logic [1:0]               out_kind_o,
  input logic [$clog2(NCOLS)-1:0] out_col_o,
  input logic [$clog2(NROWS)-1:0] out_row_o,
  input logic [PW-1:0]            out_pay_o,
  input logic                     out_eof_o
);
  localparam int CW = $clog2(NCOLS);

  logic fire;
  assign fire = out_valid_o && out_ready_i;

  a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_kind_o) &&
      $stable(out_col_o) && $stable(out_row_o) && $stable(out_pay_o)));

  a_r3_header_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_kind_o == 2'd1) |-> (out_row_o == '0 && out_pay_o[PW-1:1] == '0));

  a_r3_header_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && out_kind_o == 2'd1) |=>
      (!(out_valid_o && out_kind_o == 2'd1) || out_col_o == CW'($past(out_col_o) + 1'b1)));

  a_r4_row_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && out_kind_o == 2'd0) |=>
      (!(out_valid_o && out_kind_o == 2'd0 && out_col_o == $past(out_col_o) &&
         (out_row_o != '0 || $past(out_row_o) != '0)) || out_row_o > $past(out_row_o)));

  a_r7_eof_word: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof_o |-> (out_valid_o && out_kind_o == 2'd2 && out_col_o == '0 &&
                   out_row_o == '0 && out_pay_o == '0));

  a_r7_idle_after_eof: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && out_kind_o == 2'd2) |=> !out_valid_o);

  a_r9_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && out_kind_o != 2'd2) |=> out_valid_o);
endmodule

bind zs_col_readout zsr_checker #(.NCOLS(NCOLS), .NROWS(NROWS), .PW(PW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_kind_o  (out_kind_o),
  .out_col_o   (out_col_o),
  .out_row_o   (out_row_o),
  .out_pay_o   (out_pay_o),
  .out_eof_o   (out_eof_o)
);

// File: tb/zs_col_readout_bench.sv
module zs_col_readout_bench;
  localparam int NC   = 64;
  localparam int NR   = 64;
  localparam int PW   = 8;
  localparam int NPIX = NC * NR;
  localparam int MAXW = 4200;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               start_i = 1'b0;
  logic               compress_i = 1'b0;
  logic [NPIX-1:0]    hit_i = '0;
  logic [NPIX*PW-1:0] pay_i = '0;
  logic               out_valid_o;
  logic               out_ready_i = 1'b0;
  logic [1:0]         out_kind_o;
  logic [5:0]         out_col_o;
  logic [5:0]         out_row_o;
  logic [PW-1:0]      out_pay_o;
  logic               out_eof_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [NPIX-1:0] hmap;
  int exp_w [MAXW];
  int rx_w  [MAXW];
  int n_exp, n_rx, n_iter, stall_bad, n_stall;

  zs_col_readout #(.NCOLS(NC), .NROWS(NR), .PW(PW)) u_zs_col_readout (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .compress_i(compress_i),
    .hit_i(hit_i), .pay_i(pay_i), .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i), .out_kind_o(out_kind_o), .out_col_o(out_col_o),
    .out_row_o(out_row_o), .out_pay_o(out_pay_o), .out_eof_o(out_eof_o)
  );

  always #2 clk = ~clk;

  function automatic int pack_w(int kind, int col, int row, int pay);
    return (kind << 20) | (col << 14) | (row << 8) | pay;
  endfunction

  function automatic int pix_pay(int c, int r, int seed);
    return (c * 37 + r * 11 + seed) & 8'hFF;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic load_pay(int seed);
    for (int c = 0; c < NC; c++)
      for (int r = 0; r < NR; r++)
        pay_i[(c*NR + r)*PW +: PW] = PW'(pix_pay(c, r, seed));
  endtask

  task automatic build_exp(bit cmp, int seed);
    n_exp = 0;
    for (int c = 0; c < NC; c++) begin
      if (cmp) begin
        exp_w[n_exp] = pack_w(1, c, 0, (|hmap[c*NR +: NR]) ? 1 : 0);
        n_exp++;
      end
      for (int r = 0; r < NR; r++) begin
        if (!cmp) begin
          exp_w[n_exp] = pack_w(0, 0, 0, pix_pay(c, r, seed));
          n_exp++;
        end else if (hmap[c*NR + r]) begin
          exp_w[n_exp] = pack_w(0, c, r, pix_pay(c, r, seed));
          n_exp++;
        end
      end
    end
    exp_w[n_exp] = pack_w(2, 0, 0, 0);
    n_exp++;
  endtask

  function automatic bit ready_pat(int mode, int i);
    case (mode)
      1:       return (i % 3) != 1;
      2:       return (i % 7) >= 3;
      default: return 1'b1;
    endcase
  endfunction

  // Runs one frame from hmap; busy_poke sends a second start mid-frame.
  task automatic run_frame(bit cmp, int seed, int bp, bit busy_poke);
    int  prev_w;
    bit  prev_stall;
    int  cur;
    bit  got_eof;
    load_pay(seed);
    build_exp(cmp, seed);
    n_rx = 0; n_iter = 0; stall_bad = 0; n_stall = 0;
    prev_stall = 1'b0; prev_w = 0; got_eof = 1'b0;
    @(negedge clk);
    hit_i = hmap; compress_i = cmp; start_i = 1'b1;
    while (!got_eof && n_iter < 20000) begin
      @(negedge clk);
      if (n_iter == 0) start_i = 1'b0;
      if (busy_poke && n_iter == 10) begin
        start_i = 1'b1; compress_i = ~cmp; hit_i = '1;
      end
      if (busy_poke && n_iter == 11) start_i = 1'b0;
      out_ready_i = ready_pat(bp, n_iter);
      cur = pack_w(out_kind_o, out_col_o, out_row_o, out_pay_o);
      if (prev_stall && !(out_valid_o && cur == prev_w)) stall_bad++;
      prev_stall = out_valid_o && !out_ready_i;
      if (prev_stall) n_stall++;
      prev_w = cur;
      if (out_valid_o && out_ready_i) begin
        if (n_rx < MAXW) rx_w[n_rx] = cur;
        n_rx++;
        if (out_kind_o == 2'd2) got_eof = 1'b1;
      end
      n_iter++;
    end
    @(negedge clk);
    out_ready_i = 1'b0;
    start_i = 1'b0;
    chk(n_rx == n_exp, "R4", "frame word count", n_rx, n_exp);
    begin
      int first_bad = -1;
      for (int i = 0; i < n_exp && i < n_rx; i++)
        if (first_bad < 0 && rx_w[i] != exp_w[i]) first_bad = i;
      if (first_bad >= 0)
        chk(1'b0, cmp ? "R3/R4/R10" : "R6/R10", "word content",
            rx_w[first_bad], exp_w[first_bad]);
      else
        chk(1'b1, "R3", "word content", 0, 0);
    end
    if (n_rx > 0)
      chk(rx_w[n_rx-1] == pack_w(2, 0, 0, 0), "R7", "last word is end of frame",
          rx_w[n_rx-1], pack_w(2, 0, 0, 0));
    chk(!out_valid_o, "R7", "idle after end of frame", out_valid_o, 0);
    if (n_stall > 0) chk(stall_bad == 0, "R8", "stalled word held", stall_bad, 0);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!out_valid_o && !out_eof_o, "R1", "no word after reset",
          {out_valid_o, out_eof_o}, 0);
    end
  endtask

  task automatic t_sparse();
    hmap = '0;
    hmap[0*NR + 0]   = 1'b1;
    hmap[5*NR + 17]  = 1'b1;
    hmap[5*NR + 40]  = 1'b1;
    hmap[20*NR + 63] = 1'b1;
    hmap[63*NR + 63] = 1'b1;
    run_frame(1'b1, 3, 1, 1'b0);
    // R5: same map again, every hit reported once more and only once
    run_frame(1'b1, 9, 2, 1'b0);
    chk(n_rx == NC + 5 + 1, "R5", "repeat frame hit count", n_rx, NC + 6);
  endtask

  task automatic t_empty();
    hmap = '0;
    run_frame(1'b1, 1, 0, 1'b0);
    chk(n_iter == NC + 1, "R9", "empty frame cycles", n_iter, NC + 1);
  endtask

  task automatic t_dense();
    hmap = '0;
    hmap[10*NR +: NR] = '1;
    hmap[63*NR +: NR] = '1;
    run_frame(1'b1, 5, 0, 1'b0);
    chk(n_iter == NC + 2*NR + 1, "R9", "dense frame cycles", n_iter, NC + 2*NR + 1);
  endtask

  task automatic t_raw();
    hmap = '0;
    hmap[2*NR + 7] = 1'b1;
    hmap[40*NR +: 5] = '1;
    run_frame(1'b0, 7, 1, 1'b0);
    chk(n_rx == NPIX + 1, "R6", "raster frame length", n_rx, NPIX + 1);
  endtask

  task automatic t_busy_start();
    hmap = '0;
    hmap[1*NR + 2]   = 1'b1;
    hmap[30*NR + 31] = 1'b1;
    run_frame(1'b1, 11, 0, 1'b1);
    chk(n_rx == NC + 3, "R2", "mid-frame start ignored", n_rx, NC + 3);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_sparse();
    t_empty();
    t_dense();
    t_raw();
    t_busy_start();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule